// File: doc/BRIEF.md
# Double-Saturating Fractional Adder

This block is a signed fixed-point add/subtract unit for Q31-style fractional data. Its plain operations add or subtract two 32-bit operands and clamp the result to the signed range. Its doubling operations first multiply one operand by two, clamping that product, and then add it to or subtract it from the other operand with a second clamp. The doubling removes the redundant sign bit that a fractional multiply leaves behind, so a product can be accumulated in one operation.

Each cycle the unit accepts an operation and two operands and presents the registered result one clock later. A per-operation saturation flag tells whether either clamp acted. A sticky copy of that flag stays set until an explicit clear input removes it. No rounding is done at any stage.

Top module: `dsat_alu`

## Requirements
- R1: Operation code 2'b00 outputs opnd_a + opnd_b, clamped to the signed 32-bit range.
- R2: Operation code 2'b01 outputs opnd_a - opnd_b, clamped to the signed 32-bit range.
- R3: In the doubling operations, opnd_b is shifted left by one bit and that value is clamped to the signed 32-bit range before it is used. An operand of 0xC0000000 doubles to exactly 0x80000000 without clamping.
- R4: Operation code 2'b10 outputs opnd_a plus the clamped doubled opnd_b. Operation code 2'b11 outputs opnd_a minus the clamped doubled opnd_b. Both final values are clamped again.
- R5: Any clamp produces 0x7FFFFFFF for positive overflow and 0x80000000 for negative overflow. Results are never rounded.
- R6: sat_flag is 1 for an operation exactly when the doubling clamp or the final clamp acted. Plain operations never report a doubling clamp.
- R7: result and sat_flag appear on the first rising clock edge after the operation is presented, and each reflects only that operation.
- R8: sat_sticky becomes 1 on the edge that registers a saturating operation. It then stays 1 while sticky_clr is low.
- R9: When sticky_clr is high at an edge, sat_sticky is 0 after that edge, even if the operation in that cycle saturated.
- R10: While rst_n is low, result, sat_flag and sat_sticky are 0 whatever the inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| op_sel | input | 2 | 00 add, 01 subtract, 10 doubling add, 11 doubling subtract |
| opnd_a | input | 32 | Operand that is never doubled (minuend in subtraction) |
| opnd_b | input | 32 | Operand that is added, subtracted, or doubled first |
| sticky_clr | input | 1 | Clears the sticky saturation flag at the next edge |
| result | output | 32 | Registered saturated result |
| sat_flag | output | 1 | Registered: either clamp acted for this result |
| sat_sticky | output | 1 | Accumulated saturation indication |

## Verification
Every result and flag is due one rising edge after its operands are presented. The bench drives each new operation on a falling edge. On the next falling edge it first compares all three outputs against a model value computed from the operation driven one step earlier, and only then drives the next operation. The sticky flag is modelled from the same cycle's clear and saturation, so clear priority is checked on the edge where the two coincide. Directed vectors hit each clamp boundary in both stages, including a doubling clamp followed by a final sum that stays in range. Random vectors cover the rest.

// File: rtl/dsat_pkg.sv
package dsat_pkg;
  typedef enum logic [1:0] {
    OP_ADD  = 2'b00,
    OP_SUB  = 2'b01,
    OP_DADD = 2'b10,
    OP_DSUB = 2'b11
  } dsat_op_e;
endpackage

// File: rtl/dsat_doubler.sv
module dsat_doubler #(
  parameter int W = 32
) (
  input  logic [W-1:0] src,
  output logic [W-1:0] dbl,
  output logic         clamped
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // Doubling overflows exactly when the two top bits differ.
  function automatic logic double_overflows(input logic [W-1:0] v);
    return v[W-1] ^ v[W-2];
  endfunction

  function automatic logic [W-1:0] double_clamp(input logic [W-1:0] v);
    if (double_overflows(v)) return v[W-1] ? MINV : MAXV;
    return {v[W-2:0], 1'b0};
  endfunction

  always_comb begin
    clamped = double_overflows(src);
    dbl     = double_clamp(src);
  end
endmodule

// File: rtl/dsat_addsub.sv
module dsat_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] lhs,
  input  logic [W-1:0] rhs,
  input  logic         subtract,
  output logic [W-1:0] res,
  output logic         clamped
);
  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  // One extra bit holds any sum or difference of two W-bit signed values.
  function automatic logic [W:0] wide_result(input logic [W-1:0] x,
                                             input logic [W-1:0] y,
                                             input logic         sub);
    logic [W:0] xe, ye;
    xe = {x[W-1], x};
    ye = {y[W-1], y};
    return sub ? (xe - ye) : (xe + ye);
  endfunction

  logic [W:0] wide;

  always_comb begin
    wide    = wide_result(lhs, rhs, subtract);
    clamped = wide[W] ^ wide[W-1];
    if (clamped) res = wide[W] ? MINV : MAXV;
    else         res = wide[W-1:0];
  end
endmodule

// File: rtl/dsat_alu.sv
module dsat_alu #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   op_sel,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         sticky_clr,
  output logic [W-1:0] result,
  output logic         sat_flag,
  output logic         sat_sticky
);
  import dsat_pkg::*;

  localparam logic [W-1:0] MAXV = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {(W-1){1'b0}}};

  dsat_op_e     op;
  logic         is_double;
  logic         is_sub;
  logic [W-1:0] dbl_val;
  logic         dbl_raw_clamp;
  logic         dbl_sat;
  logic [W-1:0] rhs_val;
  logic [W-1:0] fin_val;
  logic         fin_sat;
  logic         sat_any;

  assign op        = dsat_op_e'(op_sel);
  assign is_double = (op == OP_DADD) || (op == OP_DSUB);
  assign is_sub    = (op == OP_SUB)  || (op == OP_DSUB);

  dsat_doubler #(.W(W)) u_dbl (
    .src     (opnd_b),
    .dbl     (dbl_val),
    .clamped (dbl_raw_clamp)
  );

  assign dbl_sat = is_double & dbl_raw_clamp;
  assign rhs_val = is_double ? dbl_val : opnd_b;

  dsat_addsub #(.W(W)) u_fin (
    .lhs      (opnd_a),
    .rhs      (rhs_val),
    .subtract (is_sub),
    .res      (fin_val),
    .clamped  (fin_sat)
  );

  assign sat_any = dbl_sat | fin_sat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result     <= '0;
      sat_flag   <= 1'b0;
      sat_sticky <= 1'b0;
    end else begin
      result     <= fin_val;
      sat_flag   <= sat_any;
      sat_sticky <= sticky_clr ? 1'b0 : (sat_sticky | sat_any);
    end
  end

  AST_DBL_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
    dbl_sat |-> (rhs_val == MAXV || rhs_val == MINV)); // R3
  AST_PLAIN_NO_DBL: assert property (@(posedge clk) disable iff (!rst_n)
    !is_double |-> !dbl_sat); // R6
  AST_FIN_EXTREME: assert property (@(posedge clk) disable iff (!rst_n)
    fin_sat |=> (result == MAXV || result == MINV)); // R5
  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (result == $past(fin_val))); // R7
  AST_STICKY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_any && !sticky_clr) |=> (sat_flag && sat_sticky)); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sat_sticky && !sticky_clr) |=> sat_sticky); // R8
  AST_STICKY_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    sticky_clr |=> !sat_sticky); // R9
endmodule

// File: tb/tb_dsat_alu.sv
`timescale 1ns/1ps
module tb_dsat_alu;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  op_sel = 2'b00;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        sticky_clr = 1'b0;
  logic [31:0] result;
  logic        sat_flag;
  logic        sat_sticky;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [31:0] exp_res = '0;
  logic        exp_flag = 1'b0;
  logic        exp_sticky = 1'b0;
  string       res_tag = "R1";
  string       stk_tag = "R8";

  always #4 clk = ~clk;

  dsat_alu dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .sticky_clr(sticky_clr), .result(result),
    .sat_flag(sat_flag), .sat_sticky(sat_sticky)
  );

  localparam longint LMAX = 64'sd2147483647;
  localparam longint LMIN = -64'sd2147483648;

  function automatic longint clamp32(input longint v, inout bit hit);
    if (v > LMAX) begin hit = 1'b1; return LMAX; end
    if (v < LMIN) begin hit = 1'b1; return LMIN; end
    return v;
  endfunction

  task automatic check(input bit cond, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!cond) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_outputs();
    check(result === exp_res, res_tag, "result", result, exp_res);
    check(sat_flag === exp_flag, "R6", "sat_flag", 32'(sat_flag), 32'(exp_flag));
    check(sat_sticky === exp_sticky, stk_tag, "sat_sticky",
          32'(sat_sticky), 32'(exp_sticky));
  endtask

  // R7: outputs are due one edge after drive; compare on the next falling edge.
  task automatic step(input logic [1:0] op, input logic [31:0] a,
                      input logic [31:0] b, input bit clr);
    longint la, lb, rhs, v;
    bit hit;
    @(negedge clk);
    compare_outputs();
    hit = 1'b0;
    la  = longint'($signed(a));
    lb  = longint'($signed(b));
    rhs = op[1] ? clamp32(lb * 2, hit) : lb;        // R3
    v   = op[0] ? la - rhs : la + rhs;              // R2 / R4
    v   = clamp32(v, hit);
    exp_res    = v[31:0];
    exp_flag   = hit;
    exp_sticky = clr ? 1'b0 : (exp_sticky | hit);
    stk_tag    = clr ? "R9" : "R8";
    if (v == LMAX || v == LMIN) res_tag = "R5";
    else if (op[1])             res_tag = "R4";
    else if (op[0])             res_tag = "R2";
    else                        res_tag = "R1";
    op_sel = op; opnd_a = a; opnd_b = b; sticky_clr = clr;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    // R10: reset holds outputs at zero even with saturating inputs.
    @(negedge clk);
    op_sel = 2'b10; opnd_a = 32'h7FFFFFFF; opnd_b = 32'h7FFFFFFF; sticky_clr = 1'b0;
    repeat (3) @(negedge clk);
    check(result === 32'h0, "R10", "result in reset", result, 32'h0);
    check(sat_flag === 1'b0, "R10", "sat_flag in reset", 32'(sat_flag), 32'h0);
    check(sat_sticky === 1'b0, "R10", "sat_sticky in reset", 32'(sat_sticky), 32'h0);
    op_sel = 2'b00; opnd_a = '0; opnd_b = '0;
    rst_n = 1'b1;

    // R1 / R5 plain add
    step(2'b00, 32'd5, 32'd7, 1'b0);
    step(2'b00, 32'h7FFFFFFF, 32'd1, 1'b0);
    step(2'b00, 32'h80000000, 32'hFFFFFFFF, 1'b0);
    step(2'b00, 32'h7FFFFFFF, 32'h80000000, 1'b0);
    // R2 plain subtract
    step(2'b01, 32'd10, 32'd3, 1'b0);
    step(2'b01, 32'h80000000, 32'd1, 1'b0);
    step(2'b01, 32'h00000000, 32'h80000000, 1'b0);
    step(2'b01, 32'hFFFFFFFF, 32'h7FFFFFFF, 1'b0);
    // R9 clear, then clear coinciding with a saturating op
    step(2'b00, 32'd1, 32'd1, 1'b1);
    step(2'b00, 32'h7FFFFFFF, 32'h7FFFFFFF, 1'b1);
    // R3 doubling boundaries
    step(2'b10, 32'd0, 32'h3FFFFFFF, 1'b0);
    step(2'b10, 32'd0, 32'hC0000000, 1'b0);
    step(2'b10, 32'd0, 32'h40000000, 1'b1);
    step(2'b10, 32'd0, 32'hBFFFFFFF, 1'b1);
    // R4 doubling clamp then in-range sum
    step(2'b10, 32'hFFFFFFFB, 32'h40000000, 1'b1);
    step(2'b10, 32'd3, 32'h00001000, 1'b1);
    step(2'b11, 32'd0, 32'h80000000, 1'b1);
    step(2'b11, 32'd100, 32'd25, 1'b0);
    step(2'b11, 32'h80000000, 32'd1, 1'b0);
    // R8 sticky holds across clean ops
    step(2'b00, 32'd2, 32'd2, 1'b0);
    step(2'b01, 32'd2, 32'd2, 1'b0);
    step(2'b00, 32'd2, 32'd2, 1'b1);
    // Random sweep over all operations
    for (int i = 0; i < 400; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 4 == 1) rb = {rb[31], rb[31], rb[29:0]};
      step(2'($urandom), ra, rb, ($urandom % 8) == 0);
    end
    @(negedge clk);
    compare_outputs();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule